// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block steers instruction fetch for a single hardware loop. Three registers define the loop: the address of its first instruction, the address of its last instruction, and an iteration count. Software loads them through a small register-write port. Each cycle the block sees the address of the instruction that is retiring, and whether that instruction is a taken branch with a target. From these it produces the next fetch address and exposes the current count.

The loop-back decision depends only on the count at the moment the last instruction of the loop retires. If the count is above one, the count drops by one and fetch returns to the loop's first instruction. Otherwise the count settles at zero and fetch falls through to the next address. The block does not record how execution entered the body, so entry by any jump or return is legal at any body instruction, including the last one. Instructions are a fixed 4 bytes long.

Top module: `hwloop_sequencer`

## Requirements
- R1: A synchronous active-high reset clears the count and both loop addresses. After reset the count reads 0, and a retiring instruction at any address other than 0 yields a next fetch address equal to its address plus 4.
- R2: When a retiring instruction is not at the bottom address and is not a taken branch, the next fetch address is its address plus 4, and the count is unchanged.
- R3: When the instruction at the bottom address retires with a count greater than 1, the next fetch address equals the top address, and the count is one lower in the following cycle.
- R4: When the instruction at the bottom address retires with a count of 0 or 1, the next fetch address is the bottom address plus 4, and the count is 0 in the following cycle.
- R5: When the body is entered at its top with count N, each body instruction retires max(N,1) times before execution falls through, and the count ends at 0.
- R6: When the body is entered partway through with count N, the instructions ahead of the entry point retire max(N,1)-1 times and the others retire max(N,1) times. This includes entry at the bottom instruction itself.
- R7: Execution that starts past the bottom address and never retires the bottom instruction leaves the count unchanged.
- R8: A taken branch on a retiring instruction sets the next fetch address to the branch target, even at the bottom address. At the bottom address it also leaves the count unchanged.
- R9: A count write in the same cycle as a bottom-address retire takes priority over the decrement, so the count takes the written value.
- R10: When no instruction retires and no write occurs, the count does not change.
- R11: The write select encodes 0 as top address, 1 as bottom address, 2 as count and 3 as no target. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select (0 top, 1 bottom, 2 count, 3 none) |
| wrData | input | ADDR_W | Write data; the count takes the low CNT_W bits |
| retireValid | input | 1 | An instruction retires this cycle |
| retireAddr | input | ADDR_W | Address of the retiring instruction |
| branchTaken | input | 1 | Retiring instruction is a taken branch |
| branchTarget | input | ADDR_W | Target of that branch |
| nextFetch | output | ADDR_W | Next fetch address (combinational) |
| loopCount | output | CNT_W | Current loop count |

## Verification
The bench builds the block with 12-bit addresses and a 4-bit count. With those widths it can try every count value, 0 through 15, against every entry point of a three-instruction body: top, middle and bottom, plus a start just past the loop. For each combination it tallies how many times each body instruction retires and compares the tallies and the final count with closed-form values. Directed cycles then cover branch priority, write priority, the idle state and the unused select code.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  typedef enum logic [1:0] {
    SEL_TOP    = 2'd0,
    SEL_BOTTOM = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadTop;
    logic loadBottom;
    logic loadCount;
    logic takeBranch;
    logic loopBack;
    logic decCount;
    logic clearCount;
  } seqStrobes_t;

endpackage

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
(
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic        retireValid,
  input  logic        branchTaken,
  input  logic        atBottom,
  input  logic        countGtOne,
  output seqStrobes_t strobes
);

  logic    bottomRetire;
  regSel_e selDecoded;

  always_comb begin
    selDecoded   = regSel_e'(wrSel);
    bottomRetire = retireValid && atBottom && !branchTaken;

    strobes            = '0;
    strobes.loadTop    = wrEn && (selDecoded == SEL_TOP);
    strobes.loadBottom = wrEn && (selDecoded == SEL_BOTTOM);
    strobes.loadCount  = wrEn && (selDecoded == SEL_COUNT);
    strobes.takeBranch = retireValid && branchTaken;
    strobes.loopBack   = bottomRetire && countGtOne;
    // A software write to the count overrides any automatic update.
    strobes.decCount   = bottomRetire && countGtOne && !strobes.loadCount;
    strobes.clearCount = bottomRetire && !countGtOne && !strobes.loadCount;
  end

endmodule

// File: rtl/hwloop_datapath.sv
module hwloop_datapath
  import hwloop_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [ADDR_W-1:0] retireAddr,
  input  logic [ADDR_W-1:0] branchTarget,
  output logic              atBottom,
  output logic              countGtOne,
  output logic [ADDR_W-1:0] nextFetch,
  output logic [CNT_W-1:0]  loopCount,
  output logic [ADDR_W-1:0] topAddr,
  output logic [ADDR_W-1:0] bottomAddr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] topQ, bottomQ, seqAddr;
  logic [CNT_W-1:0]  countQ, countD;

  always_ff @(posedge clk) begin
    if (rst) begin
      topQ    <= '0;
      bottomQ <= '0;
    end else begin
      if (strobes.loadTop)    topQ    <= wrData;
      if (strobes.loadBottom) bottomQ <= wrData;
    end
  end

  always_comb begin
    countD = countQ;
    if (strobes.loadCount)       countD = wrData[CNT_W-1:0];
    else if (strobes.decCount)   countD = countQ - ONE;
    else if (strobes.clearCount) countD = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) countQ <= '0;
    else     countQ <= countD;
  end

  always_comb begin
    seqAddr    = retireAddr + STEP;
    atBottom   = (retireAddr == bottomQ);
    countGtOne = (countQ > ONE);
    if (strobes.takeBranch)    nextFetch = branchTarget;
    else if (strobes.loopBack) nextFetch = topQ;
    else                       nextFetch = seqAddr;
  end

  assign loopCount  = countQ;
  assign topAddr    = topQ;
  assign bottomAddr = bottomQ;

endmodule

// File: rtl/hwloop_sequencer.sv
module hwloop_sequencer
  import hwloop_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              retireValid,
  input  logic [ADDR_W-1:0] retireAddr,
  input  logic              branchTaken,
  input  logic [ADDR_W-1:0] branchTarget,
  output logic [ADDR_W-1:0] nextFetch,
  output logic [CNT_W-1:0]  loopCount
);

  seqStrobes_t       strobes;
  logic              atBottom, countGtOne;
  logic [ADDR_W-1:0] loopTopQ, loopBottomQ;

  hwloop_ctrl u_ctrl (
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .retireValid (retireValid),
    .branchTaken (branchTaken),
    .atBottom    (atBottom),
    .countGtOne  (countGtOne),
    .strobes     (strobes)
  );

  hwloop_datapath #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .wrData       (wrData),
    .retireAddr   (retireAddr),
    .branchTarget (branchTarget),
    .atBottom     (atBottom),
    .countGtOne   (countGtOne),
    .nextFetch    (nextFetch),
    .loopCount    (loopCount),
    .topAddr      (loopTopQ),
    .bottomAddr   (loopBottomQ)
  );

endmodule

// File: rtl/hwloop_checker.sv
module hwloop_checker #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int INSN_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic [ADDR_W-1:0] wrData,
  input logic              retireValid,
  input logic [ADDR_W-1:0] retireAddr,
  input logic              branchTaken,
  input logic [ADDR_W-1:0] branchTarget,
  input logic [ADDR_W-1:0] nextFetch,
  input logic [CNT_W-1:0]  loopCount,
  input logic [ADDR_W-1:0] loopTopQ,
  input logic [ADDR_W-1:0] loopBottomQ
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic bottomHit;
  assign bottomHit = retireValid && !branchTaken && (retireAddr == loopBottomQ);

  AST_BRANCH_WINS: assert property (@(posedge clk) disable iff (rst)
    retireValid && branchTaken |-> nextFetch == branchTarget); // R8

  AST_BRANCH_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    retireValid && branchTaken && !wrEn |=> $stable(loopCount)); // R8

  AST_LOOP_BACK: assert property (@(posedge clk) disable iff (rst)
    bottomHit && loopCount > ONE |-> nextFetch == loopTopQ); // R3

  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    bottomHit && loopCount > ONE && !wrEn |=> loopCount == $past(loopCount) - ONE); // R3

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    bottomHit && loopCount <= ONE |-> nextFetch == retireAddr + STEP); // R4

  AST_EXIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    bottomHit && loopCount <= ONE && !wrEn |=> loopCount == '0); // R4

  AST_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    retireValid && !branchTaken && retireAddr != loopBottomQ |-> nextFetch == retireAddr + STEP); // R2

  AST_NON_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (rst)
    retireValid && retireAddr != loopBottomQ && !wrEn |=> $stable(loopCount)); // R7

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrSel == 2'd2 |=> loopCount == $past(wrData[CNT_W-1:0])); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !retireValid && !wrEn |=> $stable(loopCount)); // R10

  AST_NULL_SELECT: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrSel == 2'd3 && !retireValid |=> $stable(loopCount) && $stable(loopTopQ) && $stable(loopBottomQ)); // R11

endmodule

bind hwloop_sequencer hwloop_checker #(
  .ADDR_W     (ADDR_W),
  .CNT_W      (CNT_W),
  .INSN_BYTES (INSN_BYTES)
) u_checker (
  .clk          (clk),
  .rst          (rst),
  .wrEn         (wrEn),
  .wrSel        (wrSel),
  .wrData       (wrData),
  .retireValid  (retireValid),
  .retireAddr   (retireAddr),
  .branchTaken  (branchTaken),
  .branchTarget (branchTarget),
  .nextFetch    (nextFetch),
  .loopCount    (loopCount),
  .loopTopQ     (loopTopQ),
  .loopBottomQ  (loopBottomQ)
);

// File: tb/hwloop_sequencer_bench.sv
`timescale 1ns/1ps
module hwloop_sequencer_bench;

  localparam int AW = 12;
  localparam int CW = 4;
  localparam logic [AW-1:0] TOP  = 12'h100;
  localparam logic [AW-1:0] BOT  = 12'h108;
  localparam logic [AW-1:0] PAST = 12'h10C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic [1:0]    wrSel = 2'd0;
  logic [AW-1:0] wrData = '0;
  logic          retireValid = 1'b0;
  logic [AW-1:0] retireAddr = '0;
  logic          branchTaken = 1'b0;
  logic [AW-1:0] branchTarget = '0;
  logic [AW-1:0] nextFetch;
  logic [CW-1:0] loopCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hwloop_sequencer #(.ADDR_W(AW), .CNT_W(CW), .INSN_BYTES(4)) u_hwloop_sequencer (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .retireValid(retireValid), .retireAddr(retireAddr),
    .branchTaken(branchTaken), .branchTarget(branchTarget),
    .nextFetch(nextFetch), .loopCount(loopCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wrEn = 1'b0; retireValid = 1'b0; branchTaken = 1'b0;
    #0.5;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] data);
    @(negedge clk);
    retireValid = 1'b0; branchTaken = 1'b0;
    wrEn = 1'b1; wrSel = sel; wrData = data;
    idle();
  endtask

  task automatic retire(input logic [AW-1:0] addr, input logic br,
                        input logic [AW-1:0] tgt, output logic [AW-1:0] nf);
    @(negedge clk);
    wrEn = 1'b0; retireValid = 1'b1; retireAddr = addr;
    branchTaken = br; branchTarget = tgt;
    #0.5;
    nf = nextFetch;
  endtask

  // Run the loop body from an entry point until fetch leaves the body.
  task automatic runLoop(input int entry, input int cnt);
    int hits[3];
    int eff, expHits, steps;
    logic [AW-1:0] pc, nf;
    string req;
    for (int i = 0; i < 3; i++) hits[i] = 0;
    wr(2'd2, AW'(cnt));
    pc = TOP + AW'(4 * entry);
    steps = 0;
    do begin
      retire(pc, 1'b0, '0, nf);
      if (pc >= TOP && pc <= BOT) hits[(pc - TOP) / 4]++;
      pc = nf;
      steps++;
    end while (pc >= TOP && pc <= BOT && steps < 200);
    idle();
    eff = (cnt == 0) ? 1 : cnt;
    req = (entry == 0) ? "R5" : (entry == 3) ? "R7" : "R6";
    for (int i = 0; i < 3; i++) begin
      if (entry == 3)    expHits = 0;
      else if (i < entry) expHits = eff - 1;
      else               expHits = eff;
      chk($sformatf("%s retire tally insn %0d entry %0d count %0d", req, i, entry, cnt), hits[i], expHits);
    end
    if (entry == 3)
      chk($sformatf("R7 count after entry past end, count %0d", cnt), int'(loopCount), cnt);
    else
      chk($sformatf("R4 final count, entry %0d count %0d", entry, cnt), int'(loopCount), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [AW-1:0] nf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #0.5;
    // R1: registers cleared
    chk("R1 count after reset", int'(loopCount), 0);
    retire(12'h040, 1'b0, '0, nf);
    chk("R1 sequential fetch after reset", int'(nf), 'h044);
    idle();
    chk("R1 count unchanged after reset retire", int'(loopCount), 0);

    wr(2'd0, TOP);
    wr(2'd1, BOT);

    // R3 single step
    wr(2'd2, 4'd5);
    retire(BOT, 1'b0, '0, nf);
    chk("R3 loop-back target", int'(nf), int'(TOP));
    idle();
    chk("R3 decremented count", int'(loopCount), 4);

    // R2 non-bottom retire
    retire(TOP + 12'd4, 1'b0, '0, nf);
    chk("R2 sequential address", int'(nf), int'(TOP) + 8);
    idle();
    chk("R2 count held", int'(loopCount), 4);

    // R4 count of 1
    wr(2'd2, 4'd1);
    retire(BOT, 1'b0, '0, nf);
    chk("R4 fall-through at count 1", int'(nf), int'(PAST));
    idle();
    chk("R4 count cleared", int'(loopCount), 0);

    // R8 branch at bottom
    wr(2'd2, 4'd3);
    retire(BOT, 1'b1, 12'h3A0, nf);
    chk("R8 branch target wins", int'(nf), 'h3A0);
    idle();
    chk("R8 count kept on branch", int'(loopCount), 3);

    // R9 same-cycle write and bottom retire
    @(negedge clk);
    retireValid = 1'b1; retireAddr = BOT; branchTaken = 1'b0;
    wrEn = 1'b1; wrSel = 2'd2; wrData = 12'd9;
    idle();
    chk("R9 write beats decrement", int'(loopCount), 9);

    // R10 idle cycles
    repeat (4) idle();
    chk("R10 count held while idle", int'(loopCount), 9);

    // R11 null select
    wr(2'd3, 12'h0F1);
    chk("R11 null select count", int'(loopCount), 9);
    wr(2'd2, 4'd2);
    retire(BOT, 1'b0, '0, nf);
    chk("R11 top address kept after null write", int'(nf), int'(TOP));
    idle();

    // Sweep every count against every entry point
    for (int c = 0; c < 16; c++)
      for (int e = 0; e < 4; e++)
        runLoop(e, c);

    finishRun();
  end

endmodule